// File: doc/BRIEF.md
# Activity-Driven Awake State Controller

This block keeps the awake/asleep state of a motion-sensing system. Upstream comparators deliver single-cycle activity and inactivity pulses; the block turns them into an awake status bit and two latched event flags, and it routes any mix of those three sources to two interrupt pins, each with its own polarity. Mapping only the awake bit to a pin turns that pin into a level output that can switch power to downstream circuitry.

Three operating modes are selected by a 2-bit field. In free mode both detectors act on every pulse. In linked mode an activity pulse counts only while asleep and an inactivity pulse only while awake, so the two detectors re-arm each other with no host reconfiguration. Loop mode adds automatic clearing: each recognised event drops the opposite flag, so the host never has to clear anything for the awake output to act as an autonomous power switch. Outside loop mode the flags stay set until the host pulses a clear strobe.

Top module: `awake_ctrl_top`

## Requirements
- R1: After reset `awake` is 1 and `actFlag`, `inactFlag` are 0.
- R2: A recognised activity pulse sets `awake` and `actFlag` at the next rising clock edge.
- R3: A recognised inactivity pulse clears `awake` and sets `inactFlag` at the next rising clock edge.
- R4: With `modeSel` = 00 (free mode) every pulse is recognised whatever the state; if activity and inactivity arrive in the same cycle, `awake` ends at 1 and both flags are set.
- R5: With `modeSel[1]` = 0 a set flag stays set until `clrStrobe`, which clears both flags at the next edge; a flag whose event is recognised in the same cycle as `clrStrobe` ends set.
- R6: With `modeSel` = 01 (linked mode) an activity pulse is ignored while `awake` is 1 and an inactivity pulse is ignored while `awake` is 0: neither `awake` nor any flag changes because of it.
- R7: With `modeSel[1]` = 1 (loop mode) the gating of R6 applies, and a recognised activity pulse also clears `inactFlag` while a recognised inactivity pulse also clears `actFlag`, with no host clear.
- R8: Pin p of `irqOut` is the OR of its mapped sources XOR `irqInvert[p]`; its map is `irqMap[3p+2:3p]` with bit 0 selecting `actFlag`, bit 1 `inactFlag`, bit 2 `awake`; with only bit 2 set the pin follows `awake` as a level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 2 | 00 free, 01 linked, 1x loop |
| actPulse | input | 1 | Activity detection pulse |
| inactPulse | input | 1 | Inactivity detection pulse |
| clrStrobe | input | 1 | Host clear of both event flags |
| irqMap | input | 6 | Source mask per pin, 3 bits per pin |
| irqInvert | input | 2 | Per-pin polarity invert |
| awake | output | 1 | Awake status |
| actFlag | output | 1 | Latched activity event |
| inactFlag | output | 1 | Latched inactivity event |
| irqOut | output | 2 | Interrupt pins |

## Verification
Directed sequences first walk each mode through its corners: a pulse arriving in the state where linked gating must drop it, both pulses in one cycle in free mode, and a clear strobe coinciding with an event, which separates set-wins from clear-wins priority. Long random runs then mix pulse densities, clear strobes, mode changes and pin maps against a cycle model in the bench, so that free, linked and loop behaviour are told apart by whether the opposite flag survives and whether a pulse in the wrong state moves anything. Random maps and polarities on both pins expose a swapped source bit or an inverted pin.

// File: rtl/awk_pkg.sv
package awk_pkg;
  localparam int unsigned SRC_COUNT = 3;
  localparam int unsigned SRC_ACT   = 0;
  localparam int unsigned SRC_INACT = 1;
  localparam int unsigned SRC_AWAKE = 2;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'b00,
    MODE_LINKED = 2'b01,
    MODE_LOOP   = 2'b10,
    MODE_LOOP2  = 2'b11
  } awkMode_e;

  typedef struct packed {
    logic setAwake;
    logic clrAwake;
    logic setAct;
    logic setInact;
    logic dropAct;
    logic dropInact;
  } awkStrobe_t;
endpackage

// File: rtl/awk_ctrl.sv
module awk_ctrl
  import awk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       actPulse,
  input  logic       inactPulse,
  input  logic       clrStrobe,
  input  logic       awakeNow,
  output awkStrobe_t stb
);
  awkMode_e mode;
  logic gated, loopOn, actSeen, inactSeen;

  assign mode   = awkMode_e'(modeSel);
  assign gated  = (mode != MODE_FREE);
  assign loopOn = (mode == MODE_LOOP) || (mode == MODE_LOOP2);

  always_comb begin
    actSeen   = actPulse   && (!gated || !awakeNow);
    inactSeen = inactPulse && (!gated ||  awakeNow);
    stb.setAwake  = actSeen;
    stb.clrAwake  = inactSeen;
    stb.setAct    = actSeen;
    stb.setInact  = inactSeen;
    stb.dropAct   = clrStrobe || (loopOn && inactSeen);
    stb.dropInact = clrStrobe || (loopOn && actSeen);
  end

  // R6/R7: gated modes never raise both events in one cycle
  p_gated_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    gated |-> !(stb.setAct && stb.setInact));
endmodule

// File: rtl/awk_datapath.sv
module awk_datapath
  import awk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  awkStrobe_t stb,
  output logic       awakeQ,
  output logic       actQ,
  output logic       inactQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      awakeQ <= 1'b1;
      actQ   <= 1'b0;
      inactQ <= 1'b0;
    end else begin
      if (stb.setAwake)      awakeQ <= 1'b1;
      else if (stb.clrAwake) awakeQ <= 1'b0;
      actQ   <= stb.setAct   | (actQ   & ~stb.dropAct);
      inactQ <= stb.setInact | (inactQ & ~stb.dropInact);
    end
  end

  p_act_wakes_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setAwake |=> (awakeQ && actQ));
  p_inact_sleeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrAwake && !stb.setAwake) |=> (!awakeQ && inactQ));
endmodule

// File: rtl/awk_irq_map.sv
module awk_irq_map #(
  parameter int unsigned NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0] srcVec,
  input  logic [NUM_SRC-1:0] mapMask,
  input  logic               invert,
  output logic               pinOut
);
  assign pinOut = (|(srcVec & mapMask)) ^ invert;
endmodule

// File: rtl/awake_ctrl_top.sv
module awake_ctrl_top
  import awk_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 2,
  localparam int unsigned MAP_W = NUM_IRQ * SRC_COUNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic               actPulse,
  input  logic               inactPulse,
  input  logic               clrStrobe,
  input  logic [MAP_W-1:0]   irqMap,
  input  logic [NUM_IRQ-1:0] irqInvert,
  output logic               awake,
  output logic               actFlag,
  output logic               inactFlag,
  output logic [NUM_IRQ-1:0] irqOut
);
  awkStrobe_t stb;
  logic [SRC_COUNT-1:0] srcVec;

  awk_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .actPulse(actPulse),
    .inactPulse(inactPulse), .clrStrobe(clrStrobe), .awakeNow(awake), .stb(stb)
  );

  awk_datapath dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .awakeQ(awake), .actQ(actFlag), .inactQ(inactFlag)
  );

  always_comb begin
    srcVec = '0;
    srcVec[SRC_ACT]   = actFlag;
    srcVec[SRC_INACT] = inactFlag;
    srcVec[SRC_AWAKE] = awake;
  end

  for (genvar p = 0; p < NUM_IRQ; p++) begin : g_pin
    awk_irq_map #(.NUM_SRC(SRC_COUNT)) map_i (
      .srcVec(srcVec),
      .mapMask(irqMap[p*SRC_COUNT +: SRC_COUNT]),
      .invert(irqInvert[p]),
      .pinOut(irqOut[p])
    );
  end

  p_hold_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && !clrStrobe && actFlag) |=> actFlag);
  p_linked_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && awake && actPulse && !inactPulse && !clrStrobe)
      |=> ($stable(actFlag) && awake));
  p_loop_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[1] && !awake && actPulse) |=> (awake && actFlag && !inactFlag));
  p_awake_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqMap[2:0] == 3'b100 && !irqInvert[0]) |-> (irqOut[0] == awake));
endmodule

// File: tb/awake_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module awake_ctrl_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic actPulse = 1'b0, inactPulse = 1'b0, clrStrobe = 1'b0;
  logic [5:0] irqMap = 6'b0;
  logic [1:0] irqInvert = 2'b0;
  logic awake, actFlag, inactFlag;
  logic [1:0] irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [2:0] model;  // {awake, act, inact}

  always #2.5 clk = ~clk;

  awake_ctrl_top dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .actPulse(actPulse),
    .inactPulse(inactPulse), .clrStrobe(clrStrobe), .irqMap(irqMap),
    .irqInvert(irqInvert), .awake(awake), .actFlag(actFlag),
    .inactFlag(inactFlag), .irqOut(irqOut)
  );

  function automatic logic [2:0] nextState(logic [2:0] s, logic [1:0] m,
                                           logic a, logic i, logic c);
    logic aw, na, ni, recA, recI, nw;
    aw = s[2]; na = s[1]; ni = s[0];
    recA = a && (m == 2'b00 || !aw);
    recI = i && (m == 2'b00 ||  aw);
    nw = recA ? 1'b1 : (recI ? 1'b0 : aw);
    if (c) begin na = 1'b0; ni = 1'b0; end
    if (m[1]) begin
      if (recA) ni = 1'b0;
      if (recI) na = 1'b0;
    end
    if (recA) na = 1'b1;
    if (recI) ni = 1'b1;
    return {nw, na, ni};
  endfunction

  function automatic logic [1:0] expIrq(logic [2:0] s, logic [5:0] mp, logic [1:0] inv);
    logic [2:0] src;
    logic [1:0] r;
    src = {s[2], s[0], s[1]};  // bit2 awake, bit1 inact, bit0 act
    for (int p = 0; p < 2; p++) r[p] = (|(src & mp[p*3 +: 3])) ^ inv[p];
    return r;
  endfunction

  task automatic compare(string tag);
    logic [1:0] ei;
    ei = expIrq(model, irqMap, irqInvert);
    checks++;
    if ({awake, actFlag, inactFlag} !== model) begin
      fails++;
      $display("FAIL %s: state {awake,act,inact} actual %b expected %b", tag,
               {awake, actFlag, inactFlag}, model);
    end
    checks++;
    if (irqOut !== ei) begin
      fails++;
      $display("FAIL R8 (%s): irqOut actual %b expected %b", tag, irqOut, ei);
    end
  endtask

  task automatic step(logic [1:0] m, logic a, logic i, logic c, string tag);
    modeSel = m; actPulse = a; inactPulse = i; clrStrobe = c;
    @(posedge clk);
    model = nextState(model, m, a, i, c);
    @(negedge clk);
    actPulse = 0; inactPulse = 0; clrStrobe = 0;
    compare(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    irqMap = 6'b100_100;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    model = 3'b100;
    compare("R1 reset state");

    // free mode directed
    step(2'b00, 1, 0, 0, "R2 activity while awake");
    step(2'b00, 0, 1, 0, "R3 inactivity");
    step(2'b00, 0, 0, 0, "R5 flags held");
    step(2'b00, 0, 0, 1, "R5 host clear");
    step(2'b00, 1, 1, 0, "R4 both pulses");
    step(2'b00, 1, 0, 1, "R5 clear with activity");
    // linked mode
    step(2'b01, 0, 0, 1, "R5 clear");
    step(2'b01, 1, 0, 0, "R6 activity ignored while awake");
    step(2'b01, 0, 1, 0, "R3 linked inactivity");
    step(2'b01, 0, 1, 0, "R6 inactivity ignored while asleep");
    step(2'b01, 1, 0, 0, "R2 linked activity");
    // loop mode
    step(2'b10, 0, 1, 0, "R7 inactivity drops act flag");
    step(2'b10, 1, 0, 0, "R7 activity drops inact flag");
    step(2'b11, 1, 1, 0, "R7 both pulses while awake");
    // irq polarity
    irqMap = 6'b001_100; irqInvert = 2'b10;
    step(2'b10, 0, 0, 0, "R8 level and inverted pin");
    irqMap = 6'b010_011; irqInvert = 2'b01;
    step(2'b10, 0, 0, 0, "R8 flag mapping");

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] m;
      string tag;
      if (n % 40 == 0) modeSel = 2'($urandom_range(0, 3));
      m = modeSel;
      irqMap = 6'($urandom);
      irqInvert = 2'($urandom);
      tag = (m == 2'b00) ? "R4 random free" : (m == 2'b01) ? "R6 random linked" : "R7 random loop";
      step(m, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 15) == 0), tag);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule